// File: doc/BRIEF.md
# Colour Channel Sequencer and Mux Control

This block produces the colour-select code for the shared converter path of a three-colour analog front end. It runs on the converter sample clock. In the normal three-colour mode it steps the select through red, green and blue, so each colour is sampled at one third of the clock rate. An active-low line-start input pulls the rotation back to red so that every scan line begins on the same colour.

The rotation can be set aside in two ways. A configuration bit pins the select to one colour chosen by a two-bit pointer. An active-low external override hands the choice to two pointer pins, and it takes priority over both the pinned and the rotating select.

Separately, an active-low test control picks which colour's gain-stage output goes to the analog test pin. A colour tag follows the select through a delay line as long as the converter latency, so each output word carries the colour it was sampled from. A reserved pointer code is never passed on. It holds the previous value and sets a sticky error flag.

Top module: `colour_seq_ctrl`

## Requirements
- R1: After reset, mux_sel, test_sel and tag_out are 00 (red), test_en is 0 and ptr_err is 0.
- R2: line_start_n is registered once. If it is sampled low at a clock edge, then with no override active and single mode off, mux_sel is 00 (red) after the following edge, and it stays red for as long as line_start_n remains low.
- R3: The colour codes are 00 red, 01 green and 10 blue. With line_start_n sampled high at edge k, mux_sel changes from red to green at edge k+1. After that it steps 00, 01, 10, 00 on every edge.
- R4: With ext_mux_n high and cfg_single high, mux_sel takes the value of cfg_color one edge after sampling, whatever line_start_n does.
- R5: With ext_mux_n low, mux_sel takes the value of ext_ptr one edge after sampling, whatever cfg_single, cfg_color and line_start_n are.
- R6: A reserved code 11 on the active pointer source (ext_ptr under override, otherwise cfg_color in single mode) leaves mux_sel at its previous value. mux_sel and tag_out are never 11.
- R7: With test_n low, test_en is 1 after the edge, and test_sel takes test_ptr (a code of 11 leaves it unchanged). With test_n high, test_en is 0 and test_sel holds.
- R8: ptr_err goes to 1 one edge after a reserved code 11 is sampled on an active pointer source (R6 sources, or test_ptr while test_n is low). It stays at 1 until reset. A code of 11 on an inactive source does not set it.
- R9: After every edge, tag_out equals the mux_sel value from LATENCY edges earlier (default 2). Before that many edges have passed since reset, it reads red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start_n | input | 1 | Start of line, active low |
| cfg_single | input | 1 | Single-colour mode enable |
| cfg_color | input | 2 | Colour pointer for single-colour mode |
| ext_mux_n | input | 1 | External mux override, active low |
| ext_ptr | input | 2 | External colour pointer |
| test_n | input | 1 | Test routing enable, active low |
| test_ptr | input | 2 | Test output colour pointer |
| mux_sel | output | 2 | Colour select for the converter mux |
| test_sel | output | 2 | Colour select for the test output |
| test_en | output | 1 | Test routing active |
| tag_out | output | 2 | Colour tag aligned with the converter output word |
| ptr_err | output | 1 | Sticky flag: reserved pointer code seen |

## Verification
A rotation counter that has slipped shows at mux_sel on the next edge as a wrong colour or a repeated colour. It also shows LATENCY edges later on tag_out, so that every following output word carries the wrong colour label. A line-start register that is missing or doubled moves the return to red, and the green that follows it, by one edge. A bench that predicts red at exactly the second edge after the pin falls catches this. A faulty priority or hold path gives a wrong select on the first edge after the pointer changes, and a faulty error latch reads 0 one edge after the reserved code, or drops back to 0 later.

// File: rtl/colour_seq_pkg.sv
package colour_seq_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] COL_RED   = 2'd0;
  localparam logic [SEL_W-1:0] COL_GREEN = 2'd1;
  localparam logic [SEL_W-1:0] COL_BLUE  = 2'd2;
  localparam logic [SEL_W-1:0] COL_RSVD  = 2'd3;

  // Next colour in the red -> green -> blue rotation; any other code restarts at red.
  function automatic logic [SEL_W-1:0] next_colour(input logic [SEL_W-1:0] c);
    case (c)
      COL_RED:   next_colour = COL_GREEN;
      COL_GREEN: next_colour = COL_BLUE;
      default:   next_colour = COL_RED;
    endcase
  endfunction

  function automatic logic is_reserved(input logic [SEL_W-1:0] c);
    is_reserved = (c == COL_RSVD);
  endfunction

  // Accept a pointer unless it is reserved, in which case keep the old value.
  function automatic logic [SEL_W-1:0] take_or_hold(input logic [SEL_W-1:0] ptr,
                                                    input logic [SEL_W-1:0] old);
    take_or_hold = is_reserved(ptr) ? old : ptr;
  endfunction
endpackage

// File: rtl/colour_rotator.sv
module colour_rotator
  import colour_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start_n,
  output logic             line_rst,
  output logic [SEL_W-1:0] rot,
  output logic [SEL_W-1:0] rot_nxt
);
  logic ls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ls_q <= 1'b1;
    else        ls_q <= line_start_n;
  end

  assign line_rst = ~ls_q;
  assign rot_nxt  = line_rst ? COL_RED : next_colour(rot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rot <= COL_RED;
    else        rot <= rot_nxt;
  end
endmodule

// File: rtl/colour_select.sv
module colour_select
  import colour_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rot_nxt,
  input  logic             cfg_single,
  input  logic [SEL_W-1:0] cfg_color,
  input  logic             ext_mux_n,
  input  logic [SEL_W-1:0] ext_ptr,
  input  logic             test_n,
  input  logic [SEL_W-1:0] test_ptr,
  output logic [SEL_W-1:0] mux_sel,
  output logic [SEL_W-1:0] test_sel,
  output logic             test_en,
  output logic             ptr_err,
  output logic             rsvd_evt
);
  logic [SEL_W-1:0] sel_nxt;
  logic             mux_rsvd;
  logic             tst_rsvd;

  always_comb begin
    if (!ext_mux_n) begin
      sel_nxt  = take_or_hold(ext_ptr, mux_sel);
      mux_rsvd = is_reserved(ext_ptr);
    end else if (cfg_single) begin
      sel_nxt  = take_or_hold(cfg_color, mux_sel);
      mux_rsvd = is_reserved(cfg_color);
    end else begin
      sel_nxt  = rot_nxt;
      mux_rsvd = 1'b0;
    end
  end

  assign tst_rsvd = ~test_n & is_reserved(test_ptr);
  assign rsvd_evt = mux_rsvd | tst_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel  <= COL_RED;
      test_sel <= COL_RED;
      test_en  <= 1'b0;
      ptr_err  <= 1'b0;
    end else begin
      mux_sel <= sel_nxt;
      test_en <= ~test_n;
      if (!test_n) test_sel <= take_or_hold(test_ptr, test_sel);
      if (rsvd_evt) ptr_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tag_delay.sv
module tag_delay #(
  parameter int LATENCY = 2,
  parameter int W       = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (LATENCY == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stage [LATENCY];
      for (genvar i = 0; i < LATENCY; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      stage[i] <= '0;
          else if (i == 0) stage[i] <= din;
          else             stage[i] <= stage[(i == 0) ? 0 : i-1];
        end
      end
      assign dout = stage[LATENCY-1];
    end
  endgenerate
endmodule

// File: rtl/colour_seq_ctrl.sv
module colour_seq_ctrl
  import colour_seq_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start_n,
  input  logic       cfg_single,
  input  logic [1:0] cfg_color,
  input  logic       ext_mux_n,
  input  logic [1:0] ext_ptr,
  input  logic       test_n,
  input  logic [1:0] test_ptr,
  output logic [1:0] mux_sel,
  output logic [1:0] test_sel,
  output logic       test_en,
  output logic [1:0] tag_out,
  output logic       ptr_err
);
  logic             line_rst;
  logic [SEL_W-1:0] rot;
  logic [SEL_W-1:0] rot_nxt;
  logic             rsvd_evt;

  colour_rotator u_rot (
    .clk(clk), .rst_n(rst_n), .line_start_n(line_start_n),
    .line_rst(line_rst), .rot(rot), .rot_nxt(rot_nxt)
  );

  colour_select u_sel (
    .clk(clk), .rst_n(rst_n), .rot_nxt(rot_nxt),
    .cfg_single(cfg_single), .cfg_color(cfg_color),
    .ext_mux_n(ext_mux_n), .ext_ptr(ext_ptr),
    .test_n(test_n), .test_ptr(test_ptr),
    .mux_sel(mux_sel), .test_sel(test_sel), .test_en(test_en),
    .ptr_err(ptr_err), .rsvd_evt(rsvd_evt)
  );

  tag_delay #(.LATENCY(LATENCY), .W(SEL_W)) u_tag (
    .clk(clk), .rst_n(rst_n), .din(mux_sel), .dout(tag_out)
  );
endmodule

// File: rtl/colour_seq_ctrl_chk.sv
module colour_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_single,
  input logic [1:0] cfg_color,
  input logic       ext_mux_n,
  input logic [1:0] ext_ptr,
  input logic       test_n,
  input logic [1:0] test_ptr,
  input logic [1:0] mux_sel,
  input logic [1:0] test_sel,
  input logic       test_en,
  input logic [1:0] tag_out,
  input logic       ptr_err,
  input logic       line_rst,
  input logic [1:0] rot,
  input logic       rsvd_evt
);
  assert_line_red_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rst && ext_mux_n && !cfg_single) |=> (mux_sel == 2'd0));

  assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_rst) |=> (rot != $past(rot)) && (rot != 2'd3));

  assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mux_n && cfg_single && cfg_color != 2'd3) |=> (mux_sel == $past(cfg_color)));

  assert_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mux_n && ext_ptr != 2'd3) |=> (mux_sel == $past(ext_ptr)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mux_n && ext_ptr == 2'd3) |=> $stable(mux_sel));

  assert_no_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != 2'd3) && (tag_out != 2'd3));

  assert_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_n && test_ptr != 2'd3) |=> (test_en && test_sel == $past(test_ptr)));

  assert_test_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_n |=> (!test_en && $stable(test_sel)));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_evt |=> ptr_err);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_err |=> ptr_err);
endmodule

bind colour_seq_ctrl colour_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_single(cfg_single), .cfg_color(cfg_color),
  .ext_mux_n(ext_mux_n), .ext_ptr(ext_ptr), .test_n(test_n), .test_ptr(test_ptr),
  .mux_sel(mux_sel), .test_sel(test_sel), .test_en(test_en), .tag_out(tag_out),
  .ptr_err(ptr_err), .line_rst(line_rst), .rot(rot), .rsvd_evt(rsvd_evt)
);

// File: tb/colour_seq_ctrl_test.sv
`timescale 1ns/1ps
module colour_seq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start_n = 1'b1;
  logic cfg_single = 1'b0;
  logic [1:0] cfg_color = 2'd0;
  logic ext_mux_n = 1'b1;
  logic [1:0] ext_ptr = 2'd0;
  logic test_n = 1'b1;
  logic [1:0] test_ptr = 2'd0;
  logic [1:0] mux_sel, test_sel, tag_out;
  logic test_en, ptr_err;

  int n_cmp = 0;
  int n_bad = 0;
  string ph = "R1";
  bit done = 0;

  // bench-side expectations
  int m_ls, m_phase, m_sel, m_tsel, m_ten, m_err, m_h1, m_tag;

  always #4 clk = ~clk;

  colour_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .line_start_n(line_start_n),
    .cfg_single(cfg_single), .cfg_color(cfg_color),
    .ext_mux_n(ext_mux_n), .ext_ptr(ext_ptr),
    .test_n(test_n), .test_ptr(test_ptr),
    .mux_sel(mux_sel), .test_sel(test_sel), .test_en(test_en),
    .tag_out(tag_out), .ptr_err(ptr_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ls = 1; m_phase = 0; m_sel = 0; m_tsel = 0; m_ten = 0; m_err = 0; m_h1 = 0; m_tag = 0;
  endtask

  task automatic compare_all();
    chk(ph, "mux_sel", int'(mux_sel), m_sel);
    chk((ph == "R1") ? "R1" : "R7", "test_sel", int'(test_sel), m_tsel);
    chk((ph == "R1") ? "R1" : "R7", "test_en", int'(test_en), m_ten);
    chk((ph == "R1") ? "R1" : "R9", "tag_out", int'(tag_out), m_tag);
    chk((ph == "R1") ? "R1" : "R8", "ptr_err", int'(ptr_err), m_err);
  endtask

  // one clock: update expectations at the edge, compare at the falling edge
  task automatic cyc();
    int old_sel;
    @(posedge clk);
    old_sel = m_sel;
    m_phase = (m_ls == 0) ? 0 : (m_phase + 1) % 3;
    if (!ext_mux_n) begin
      if (ext_ptr == 2'd3) m_err = 1; else m_sel = int'(ext_ptr);
    end else if (cfg_single) begin
      if (cfg_color == 2'd3) m_err = 1; else m_sel = int'(cfg_color);
    end else begin
      m_sel = m_phase;
    end
    if (!test_n) begin
      if (test_ptr == 2'd3) m_err = 1; else m_tsel = int'(test_ptr);
    end
    m_ten = test_n ? 0 : 1;
    m_tag = m_h1;
    m_h1 = old_sel;
    m_ls = int'(line_start_n);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    line_start_n = 1'b1; cfg_single = 1'b0; cfg_color = 2'd0;
    ext_mux_n = 1'b1; ext_ptr = 2'd0; test_n = 1'b1; test_ptr = 2'd0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    model_reset();
    do_reset();
    ph = "R1";
    compare_all();
    cyc();

    // free rotation
    ph = "R3";
    repeat (12) cyc();

    // line start pulses of several lengths at each rotation phase
    for (int len = 1; len <= 3; len++) begin
      for (int off = 0; off < 3; off++) begin
        ph = "R3";
        repeat (off + 1) cyc();
        ph = "R2";
        line_start_n = 1'b0;
        repeat (len) cyc();
        line_start_n = 1'b1;
        cyc();
        ph = "R3";
        repeat (4) cyc();
      end
    end

    // single colour, with line start wiggling underneath
    ph = "R4";
    cfg_single = 1'b1;
    for (int c = 0; c < 3; c++) begin
      cfg_color = 2'(c);
      for (int k = 0; k < 4; k++) begin
        line_start_n = k[0];
        cyc();
      end
    end
    line_start_n = 1'b1;

    // external override beats single and rotation; reserved single code ignored while overridden
    ph = "R5";
    for (int s = 0; s < 2; s++) begin
      cfg_single = s[0];
      cfg_color = 2'd3;
      ext_mux_n = 1'b0;
      for (int p = 0; p < 3; p++) begin
        ext_ptr = 2'(2 - p);
        line_start_n = p[0];
        repeat (2) cyc();
      end
      ext_mux_n = 1'b1;
      cfg_color = 2'd0;
      line_start_n = 1'b1;
      ph = (s == 0) ? "R3" : "R4";
      repeat (2) cyc();
      ph = "R5";
    end
    cfg_single = 1'b0;

    // test routing; reserved test code ignored while test routing is off
    ph = "R3";
    test_ptr = 2'd3;
    repeat (2) cyc();
    for (int t = 0; t < 3; t++) begin
      test_n = 1'b0;
      test_ptr = 2'(t);
      repeat (2) cyc();
      test_n = 1'b1;
      test_ptr = 2'd3;
      cyc();
    end
    chk("R8", "no err from inactive reserved codes", int'(ptr_err), 0);

    // reserved external code holds and flags
    do_reset();
    ph = "R5";
    ext_mux_n = 1'b0; ext_ptr = 2'd2;
    repeat (2) cyc();
    ph = "R6";
    ext_ptr = 2'd3;
    repeat (3) cyc();
    chk("R6", "ext hold value", int'(mux_sel), 2);
    chk("R8", "err after ext reserved", int'(ptr_err), 1);
    ext_mux_n = 1'b1;
    repeat (6) cyc();
    chk("R8", "err sticky", int'(ptr_err), 1);

    // reserved single code holds and flags
    do_reset();
    ph = "R4";
    cfg_single = 1'b1; cfg_color = 2'd1;
    repeat (2) cyc();
    ph = "R6";
    cfg_color = 2'd3;
    repeat (3) cyc();
    chk("R6", "single hold value", int'(mux_sel), 1);
    chk("R8", "err after single reserved", int'(ptr_err), 1);

    // reserved test code holds and flags
    do_reset();
    ph = "R3";
    test_n = 1'b0; test_ptr = 2'd2;
    repeat (2) cyc();
    test_ptr = 2'd3;
    repeat (3) cyc();
    chk("R7", "test hold value", int'(test_sel), 2);
    chk("R8", "err after test reserved", int'(ptr_err), 1);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule